// File: doc/BRIEF.md
# Open-Row First-Ready DRAM Channel Scheduler

This block sits in front of one DRAM channel and decides the order in which queued 256-byte requests reach the column-command bus. Each request names a slice, a bank group, a bank and a row. The block keeps a fixed-slot request queue and a small state machine per bank that tracks the open row. Each cycle it issues at most one column command and starts at most one row activation.

Requests whose row is already open win over all others, and ties go to the oldest. A request to a closed or different row first makes its bank wait through a fixed row-switch delay. Meanwhile, other banks keep issuing. Consecutive column commands are spaced by 2, 3 or 4 cycles. The spacing depends on whether the two commands share a slice and a bank group. Each issued command reports its queue slot, its target and the cycle counter value of the cycle in which it was chosen.

Each bank state machine has three named states: `BK_CLOSED` (no open row, the state after reset), `BK_OPENING` (the row-switch timer is running) and `BK_OPEN` (one row is open). Its transitions are:
- activate: `BK_CLOSED` → `BK_OPENING`
- reopen: `BK_OPEN` → `BK_OPENING`
- timer done: `BK_OPENING` → `BK_OPEN`

Top module: `chan_sched`

## Requirements
- R1: After reset every bank is in `BK_CLOSED` with no open row, the queue is empty, `req_ready` is 1, `cmd_valid` is 0 and the cycle counter is 0. The counter then adds one on every clock.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. It goes into the lowest-numbered free slot. `req_ready` is 0 exactly when all QDEPTH slots are occupied, and a request offered while it is 0 is dropped.
- R3: A request taken in cycle N to an idle bank whose row is not open starts that bank's activation in cycle N+1. Its column command is then chosen in cycle N+1+T_RS, provided no other command's spacing gets in the way.
- R4: A request whose row is open in its bank is issued before any request that needs an activation, even an older one. Among eligible open-row requests, the one taken earliest issues first.
- R5: A bank accepts an activation only outside `BK_OPENING`, and only while no queued request hits its currently open row. The oldest such request is activated, at most one per cycle, and it replaces the bank's open row.
- R6: A column command to the same slice as the previous one but to a different bank group is chosen at least 2 cycles after the previous one.
- R7: A column command to a different slice than the previous one is chosen at least 3 cycles after the previous one.
- R8: A column command to the same slice and the same bank group as the previous one is chosen at least 4 cycles after the previous one.
- R9: While one bank is in `BK_OPENING`, open-row requests to other banks still issue.
- R10: A command chosen in cycle C appears on the `cmd_*` outputs for the following cycle with `cmd_cycle` = C, and its slot is free from cycle C+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A free queue slot exists |
| req_slice | input | 2 | Target slice, 0 to 2 |
| req_bg | input | 2 | Target bank group |
| req_bank | input | 2 | Target bank within the group |
| req_row | input | 14 | Target row |
| cmd_valid | output | 1 | A column command is presented |
| cmd_idx | output | 6 | Queue slot of the issued request |
| cmd_slice | output | 2 | Slice of the issued command |
| cmd_bg | output | 2 | Bank group of the issued command |
| cmd_bank | output | 2 | Bank of the issued command |
| cmd_row | output | 14 | Row of the issued command |
| cmd_cycle | output | 32 | Counter value of the cycle the command was chosen |

## Verification
When a request is taken in cycle N, its command is due in one of two cycles. If its row is open and the spacing allows, it is due in cycle N+1. If the bank must open a row, it is due in N+1+T_RS. A spacing of 2, 3 or 4 cycles after the previous command can push either case later, and so can a queued open-row request that holds off an activation. The bench keeps a cycle counter that runs in step with the design's counter from reset. For every request it pushes the slot, the target and the exact `cmd_cycle` that the requirements predict. A monitor samples on the falling edge, one cycle after the choice, and compares each command in the order it is expected to leave.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

    typedef enum logic [1:0] {
        BK_CLOSED,
        BK_OPENING,
        BK_OPEN
    } bank_state_e;

    // Minimum distance between two column commands, from their placement.
    function automatic int col_gap(input logic same_slice, input logic same_bg,
                                   input int gap_bg, input int gap_sl, input int gap_same);
        if (!same_slice)  return gap_sl;
        else if (same_bg) return gap_same;
        else              return gap_bg;
    endfunction

endpackage

// File: rtl/dsched_bank.sv
module dsched_bank
    import dsched_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int T_RS  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] act_row_i,
    output logic             open_o,
    output logic             idle_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int CNT_W = $clog2(T_RS);

    bank_state_e      state_r;
    logic [CNT_W-1:0] cnt_r;
    logic [ROW_W-1:0] row_r;

    // State register: activation loads the timer so the row opens T_RS cycles later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= BK_CLOSED;
            cnt_r   <= '0;
            row_r   <= '0;
        end else begin
            unique case (state_r)
                BK_CLOSED, BK_OPEN: begin
                    if (act_i) begin
                        state_r <= BK_OPENING;
                        cnt_r   <= CNT_W'(T_RS - 2);
                        row_r   <= act_row_i;
                    end
                end
                BK_OPENING: begin
                    if (cnt_r == '0) state_r <= BK_OPEN;
                    else             cnt_r   <= cnt_r - 1'b1;
                end
                default: state_r <= BK_CLOSED;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        open_o = (state_r == BK_OPEN);
        idle_o = (state_r != BK_OPENING);
        row_o  = row_r;
    end

    p_act_only_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> state_r != BK_OPENING);

    p_timer_opens_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == BK_OPENING && cnt_r == '0) |=> state_r == BK_OPEN);

    p_open_row_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == BK_OPEN && !act_i) |=> (state_r == BK_OPEN && $stable(row_r)));

endmodule

// File: rtl/dsched_oldest.sv
module dsched_oldest #(
    parameter int N  = 64,
    parameter int SW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       cand_i,
    input  logic [N-1:0][SW-1:0] stamp_i,
    output logic               found_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int IW = $clog2(N);

    logic [SW-1:0] best;

    // Linear search for the candidate with the smallest arrival stamp.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (!found_o || stamp_i[i] < best)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                best    = stamp_i[i];
            end
        end
    end

    p_pick_is_candidate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> cand_i[idx_o]);

    p_found_iff_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found_o == (cand_i != '0));

endmodule

// File: rtl/chan_sched.sv
module chan_sched
    import dsched_pkg::*;
#(
    parameter int QDEPTH    = 64,
    parameter int NSLICE    = 3,
    parameter int NBG       = 4,
    parameter int NBANK     = 4,
    parameter int ROW_W     = 14,
    parameter int T_RS      = 64,
    parameter int GAP_BG    = 2,
    parameter int GAP_SL    = 3,
    parameter int GAP_SAME  = 4,
    parameter int IDX_W     = $clog2(QDEPTH),
    parameter int SL_W      = $clog2(NSLICE),
    parameter int BG_W      = $clog2(NBG),
    parameter int BK_W      = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SL_W-1:0]  req_slice,
    input  logic [BG_W-1:0]  req_bg,
    input  logic [BK_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    output logic             cmd_valid,
    output logic [IDX_W-1:0] cmd_idx,
    output logic [SL_W-1:0]  cmd_slice,
    output logic [BG_W-1:0]  cmd_bg,
    output logic [BK_W-1:0]  cmd_bank,
    output logic [ROW_W-1:0] cmd_row,
    output logic [31:0]      cmd_cycle
);
    localparam int NB   = NSLICE * NBG * NBANK;
    localparam int NB_W = $clog2(NB);

    // Queue slots.
    logic [QDEPTH-1:0]             q_valid;
    logic [SL_W-1:0]               q_slice [QDEPTH];
    logic [BG_W-1:0]               q_bg    [QDEPTH];
    logic [BK_W-1:0]               q_bank  [QDEPTH];
    logic [ROW_W-1:0]              q_row   [QDEPTH];
    logic [NB_W-1:0]               q_bidx  [QDEPTH];
    logic [QDEPTH-1:0][31:0]       q_stamp;

    // Timing state.
    logic [31:0]     now;
    logic            last_v;
    logic [31:0]     last_cycle;
    logic [SL_W-1:0] last_slice;
    logic [BG_W-1:0] last_bg;

    // Bank state.
    logic [NB-1:0]    bank_open, bank_idle, bank_act, bank_has_hit;
    logic [ROW_W-1:0] bank_row [NB];

    // Selection.
    logic [QDEPTH-1:0] hit, gap_ok, col_cand, miss_cand;
    logic              col_found, act_found, alloc_found;
    logic [IDX_W-1:0]  col_idx, act_idx, alloc_idx;
    logic [NB_W-1:0]   req_bidx;
    logic [ROW_W-1:0]  act_row;

    genvar gb;
    generate
        for (gb = 0; gb < NB; gb++) begin : g_bank
            dsched_bank #(.ROW_W(ROW_W), .T_RS(T_RS)) i_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .act_i     (bank_act[gb]),
                .act_row_i (act_row),
                .open_o    (bank_open[gb]),
                .idle_o    (bank_idle[gb]),
                .row_o     (bank_row[gb])
            );
        end
    endgenerate

    assign req_bidx = NB_W'(int'(req_slice) * (NBG * NBANK) + int'(req_bg) * NBANK + int'(req_bank));

    // Row hits, spacing and activation eligibility per slot.
    always_comb begin
        hit          = '0;
        bank_has_hit = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (q_valid[i] && bank_open[q_bidx[i]] && bank_row[q_bidx[i]] == q_row[i]) begin
                hit[i]                 = 1'b1;
                bank_has_hit[q_bidx[i]] = 1'b1;
            end
        end
        for (int i = 0; i < QDEPTH; i++) begin
            gap_ok[i]    = !last_v ||
                           ((now - last_cycle) >= 32'(col_gap(q_slice[i] == last_slice,
                                                              q_bg[i] == last_bg,
                                                              GAP_BG, GAP_SL, GAP_SAME)));
            col_cand[i]  = hit[i] && gap_ok[i];
            miss_cand[i] = q_valid[i] && !hit[i] && bank_idle[q_bidx[i]] &&
                           !bank_has_hit[q_bidx[i]];
        end
    end

    dsched_oldest #(.N(QDEPTH), .SW(32)) i_pick_col (
        .clk(clk), .rst_n(rst_n), .cand_i(col_cand), .stamp_i(q_stamp),
        .found_o(col_found), .idx_o(col_idx)
    );

    dsched_oldest #(.N(QDEPTH), .SW(32)) i_pick_act (
        .clk(clk), .rst_n(rst_n), .cand_i(miss_cand), .stamp_i(q_stamp),
        .found_o(act_found), .idx_o(act_idx)
    );

    always_comb begin
        bank_act = '0;
        act_row  = q_row[act_idx];
        if (act_found) bank_act[q_bidx[act_idx]] = 1'b1;
    end

    // Lowest free slot.
    always_comb begin
        alloc_found = 1'b0;
        alloc_idx   = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (!q_valid[i] && !alloc_found) begin
                alloc_found = 1'b1;
                alloc_idx   = IDX_W'(i);
            end
        end
        req_ready = alloc_found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid    <= '0;
            q_stamp    <= '0;
            for (int i = 0; i < QDEPTH; i++) begin
                q_slice[i] <= '0;
                q_bg[i]    <= '0;
                q_bank[i]  <= '0;
                q_row[i]   <= '0;
                q_bidx[i]  <= '0;
            end
            now        <= '0;
            last_v     <= 1'b0;
            last_cycle <= '0;
            last_slice <= '0;
            last_bg    <= '0;
            cmd_valid  <= 1'b0;
            cmd_idx    <= '0;
            cmd_slice  <= '0;
            cmd_bg     <= '0;
            cmd_bank   <= '0;
            cmd_row    <= '0;
            cmd_cycle  <= '0;
        end else begin
            now       <= now + 1'b1;
            cmd_valid <= col_found;
            if (col_found) begin
                q_valid[col_idx] <= 1'b0;
                last_v     <= 1'b1;
                last_cycle <= now;
                last_slice <= q_slice[col_idx];
                last_bg    <= q_bg[col_idx];
                cmd_idx    <= col_idx;
                cmd_slice  <= q_slice[col_idx];
                cmd_bg     <= q_bg[col_idx];
                cmd_bank   <= q_bank[col_idx];
                cmd_row    <= q_row[col_idx];
                cmd_cycle  <= now;
            end
            if (req_valid && alloc_found) begin
                q_valid[alloc_idx] <= 1'b1;
                q_slice[alloc_idx] <= req_slice;
                q_bg[alloc_idx]    <= req_bg;
                q_bank[alloc_idx]  <= req_bank;
                q_row[alloc_idx]   <= req_row;
                q_bidx[alloc_idx]  <= req_bidx;
                q_stamp[alloc_idx] <= now;
            end
        end
    end

    p_issue_on_open_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_found |-> (bank_open[q_bidx[col_idx]] && bank_row[q_bidx[col_idx]] == q_row[col_idx]));

    p_gap_bg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_found && last_v && q_slice[col_idx] == last_slice && q_bg[col_idx] != last_bg)
        |-> (now - last_cycle) >= 32'(GAP_BG));

    p_gap_slice_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_found && last_v && q_slice[col_idx] != last_slice)
        |-> (now - last_cycle) >= 32'(GAP_SL));

    p_gap_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_found && last_v && q_slice[col_idx] == last_slice && q_bg[col_idx] == last_bg)
        |-> (now - last_cycle) >= 32'(GAP_SAME));

    p_slot_freed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        col_found |=> !q_valid[$past(col_idx)]);

    p_one_activation_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_act));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (q_valid == '1));

endmodule

// File: tb/test_chan_sched.sv
module test_chan_sched;

    localparam int QD   = 4;
    localparam int TRS  = 8;
    localparam int RW   = 14;
    localparam int IW   = $clog2(QD);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_slice = '0, req_bg = '0, req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic          cmd_valid;
    logic [IW-1:0] cmd_idx;
    logic [1:0]    cmd_slice, cmd_bg, cmd_bank;
    logic [RW-1:0] cmd_row;
    logic [31:0]   cmd_cycle;

    chan_sched #(.QDEPTH(QD), .ROW_W(RW), .T_RS(TRS)) i_chan_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_slice(req_slice), .req_bg(req_bg), .req_bank(req_bank), .req_row(req_row),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_slice(cmd_slice), .cmd_bg(cmd_bg),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_cycle(cmd_cycle)
    );

    always #10 clk = ~clk;

    int now_tb;
    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) now_tb <= 0;
        else        now_tb <= now_tb + 1;

    typedef struct {
        int    idx, sl, bg, bk, row, cyc;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   vectors = 0;
    int   fails   = 0;
    bit   done    = 1'b0;

    task automatic chk(input string tag, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input int idx, sl, bg, bk, row, cyc, input string tag);
        exp_t e;
        e.idx = idx; e.sl = sl; e.bg = bg; e.bk = bk; e.row = row; e.cyc = cyc; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic send(input int sl, bg, bk, row, output int at);
        at        = now_tb;
        req_valid = 1'b1;
        req_slice = 2'(sl);
        req_bg    = 2'(bg);
        req_bank  = 2'(bk);
        req_row   = RW'(row);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares each command, in order, against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            vectors++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected command actual=idx%0d cyc%0d expected=none",
                         cmd_idx, cmd_cycle);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (int'(cmd_idx) != e.idx || int'(cmd_slice) != e.sl || int'(cmd_bg) != e.bg ||
                    int'(cmd_bank) != e.bk || int'(cmd_row) != e.row || int'(cmd_cycle) != e.cyc) begin
                    fails++;
                    $display("FAIL %s actual=idx%0d s%0d g%0d b%0d r%0d cyc%0d expected=idx%0d s%0d g%0d b%0d r%0d cyc%0d",
                             e.tag, cmd_idx, cmd_slice, cmd_bg, cmd_bank, cmd_row, cmd_cycle,
                             e.idx, e.sl, e.bg, e.bk, e.row, e.cyc);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int r, t;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1", int'(req_ready), 1, "req_ready after reset");
        chk("R1", int'(cmd_valid), 0, "cmd_valid after reset");

        // R3: closed bank needs activation then T_RS.
        send(2, 0, 0, 3, r);
        expect_cmd(0, 2, 0, 0, 3, r + 1 + TRS, "R3");
        idle(12);

        // R4/R5: X(row1), Y(row2), Z(row1) to one bank; Z passes older Y.
        send(0, 0, 0, 1, r);
        send(0, 0, 0, 2, t);
        send(0, 0, 0, 1, t);
        expect_cmd(0, 0, 0, 0, 1, r + 9,  "R3");
        expect_cmd(2, 0, 0, 0, 1, r + 13, "R4");
        expect_cmd(1, 0, 0, 0, 2, r + 22, "R5");
        idle(26);

        // Open further banks for the spacing checks.
        send(0, 1, 0, 1, r); expect_cmd(0, 0, 1, 0, 1, r + 9, "R3"); idle(12);
        send(1, 0, 0, 1, r); expect_cmd(0, 1, 0, 0, 1, r + 9, "R3"); idle(12);
        send(0, 0, 1, 1, r); expect_cmd(0, 0, 0, 1, 1, r + 9, "R3"); idle(12);

        // R6: same slice, different bank group.
        send(0, 0, 0, 2, r); send(0, 1, 0, 1, t);
        expect_cmd(0, 0, 0, 0, 2, r + 1, "R6");
        expect_cmd(1, 0, 1, 0, 1, r + 3, "R6");
        idle(8);

        // R7: different slice.
        send(0, 1, 0, 1, r); send(1, 0, 0, 1, t);
        expect_cmd(0, 0, 1, 0, 1, r + 1, "R7");
        expect_cmd(1, 1, 0, 0, 1, r + 4, "R7");
        idle(8);

        // R8: same slice, same bank group.
        send(0, 0, 0, 2, r); send(0, 0, 1, 1, t);
        expect_cmd(0, 0, 0, 0, 2, r + 1, "R8");
        expect_cmd(1, 0, 0, 1, 1, r + 5, "R8");
        idle(8);

        // R9: a hit to another bank issues during a row switch.
        send(0, 0, 0, 9, r); send(1, 0, 0, 1, t);
        expect_cmd(1, 1, 0, 0, 1, r + 2, "R9");
        expect_cmd(0, 0, 0, 0, 9, r + 9, "R9");
        idle(14);

        // R2: fill the queue, drop an extra request, drain in age order.
        send(2, 3, 3, 1, r);
        send(2, 3, 3, 2, t);
        send(2, 3, 3, 3, t);
        send(2, 3, 3, 4, t);
        expect_cmd(0, 2, 3, 3, 1, r + 9,  "R2");
        expect_cmd(1, 2, 3, 3, 2, r + 18, "R5");
        expect_cmd(2, 2, 3, 3, 3, r + 27, "R5");
        expect_cmd(3, 2, 3, 3, 4, r + 36, "R5");
        chk("R2", int'(req_ready), 0, "req_ready with full queue");
        send(2, 3, 3, 7, t);
        while (now_tb < r + 10) @(negedge clk);
        chk("R2", int'(req_ready), 1, "req_ready after first slot freed (R10)");
        idle(40);

        chk("R10", sb.size(), 0, "commands still outstanding");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule